// File: doc/BRIEF.md
# Two-Wire Serial Byte-Store Slave

This block is a slave on a two-wire I2C bus that fronts a 2048-byte store kept in on-chip registers. The store is organised as eight blocks of 256 bytes. A master selects the block through three bits inside the device-address byte and selects the byte within the block through a following word-address byte. The device has no strap pins, so one instance answers for the whole 11-bit address space.

Writes gather up to 32 bytes in a page buffer. The five low address bits step through a 32-byte page and wrap inside it. The buffer is committed to the store only when the master ends the transfer with a STOP placed right after an acknowledged byte. A self-timed write cycle then follows, and while it runs the device declines its own address, so that a master can poll for completion.

Reads come in two forms. A random read sets the pointer with a dummy write and then reads after a repeated START. A sequential read carries on from the current pointer. In both cases the pointer steps across the full 11-bit range after every byte. A write-protect input refuses data bytes. The block samples SCL and SDA on its own clock and drives SDA only through an open-drain pull-down enable.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset the SDA pull-down enable is low and the write cycle is idle, so the first device address that matches is acknowledged.
- R2: A device-address byte is acknowledged only when its upper four bits are 1010 and no write cycle is running. Bits [3:1] of that byte load address bits [10:8], and bit 0 selects read (1) or write (0). Any other upper nibble gets no acknowledge.
- R3: In a write transfer, the byte after the device address is always acknowledged and loads address bits [7:0].
- R4: Each acknowledged data byte lands at the current address, after which address bits [4:0] step by one and wrap from 31 to 0 while bits [10:5] stay unchanged. A sixth byte sent from offset 29 therefore lands at offset 2 of the same page.
- R5: Buffered bytes reach the store only on a STOP that comes directly after an acknowledged data byte. A STOP that comes part-way through a byte discards the whole transfer.
- R6: While the write-protect input is high at the end of a data byte, that byte is not acknowledged and is not stored. A transfer made only of such bytes leaves the store unchanged and starts no write cycle.
- R7: A committed write starts an internal cycle of WR_CYCLES clocks. During that cycle device addresses get no acknowledge. Once it ends, they are acknowledged again.
- R8: A random read returns the stored byte at the address set by the preceding dummy write.
- R9: During a read, the pointer steps by one after each byte is loaded and rolls from 2047 to 0. A master NACK ends the read and releases SDA, and a later read without a word address continues from the pointer.
- R10: The SDA pull-down enable changes only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level, as seen on the wired line |
| wp_i | input | 1 | Write protect, high refuses data bytes |
| sda_oe_o | output | 1 | Pulls SDA low when high |

## Verification
Two functions can fall in the same cycle. The first is the STOP that commits the page buffer. The second is the stray data bit that the rising SCL of that STOP clocks into the shift register. The bench provokes both with a STOP right after an acknowledged byte, and again with a STOP four bits into a byte. Each case is judged by polling the device address at once, expecting a busy NACK in the first case and an immediate acknowledge in the second, and then by reading the bytes back against the scoreboard. A second overlap is the acknowledge release at a falling SCL, which coincides with loading the next read byte. A per-clock monitor checks it by confirming that the pull-down enable never moves while SCL is high.

// File: rtl/eeprom_pkg.sv
// Shared constants and the transfer state type for the serial byte-store slave.
package eeprom_pkg;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } slv_state_t;
endpackage

// File: rtl/i2c_line_sampler.sv
// Synchronises SCL and SDA to clk and flags edges, START and STOP.
// Assumes clk runs well above the bus bit rate, so every SCL phase spans several clocks.
module i2c_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_prev, sda_prev;

    // Two-flop synchronisers plus one previous-value stage; the idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_prev <= scl_sync[1];
            sda_prev <= sda_sync[1];
        end
    end

    // Edge and bus-condition decode from the current and previous samples.
    always_comb begin
        scl_s    = scl_sync[1];
        sda_s    = sda_sync[1];
        scl_rise = scl_s & ~scl_prev;
        scl_fall = ~scl_s & scl_prev;
        start_p  = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_p   = scl_s & scl_prev & ~sda_prev & sda_s;
    end
endmodule

// File: rtl/eeprom_page_buf.sv
// Holds the bytes of one write transfer, indexed by the low address bits, with a valid mask.
// Assumes a clear and a write never arrive in the same cycle.
module eeprom_page_buf #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          we_i,
    input  logic [PW-1:0] idx_i,
    input  logic [7:0]    byte_i,
    output logic [(1<<PW)-1:0] mask_o,
    output logic [7:0]    bytes_o [1<<PW]
);
    localparam int NB = 1 << PW;

    // Valid mask: emptied at each START, one bit set per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_o <= '0;
        else if (clr_i) mask_o <= '0;
        else if (we_i)  mask_o[idx_i] <= 1'b1;
    end

    // Byte storage, guarded by the mask, so it needs no reset.
    always_ff @(posedge clk) begin
        if (we_i) bytes_o[idx_i] <= byte_i;
    end

    logic unused_nb;
    assign unused_nb = (NB == 0);
endmodule

// File: rtl/eeprom_store.sv
// The byte array and the self-timed write cycle; a commit copies every valid buffer
// byte into one page and then holds busy for WR_CYCLES clocks.
// Assumes no commit is requested while busy.
module eeprom_store #(
    parameter int AW        = 11,
    parameter int PW        = 5,
    parameter int WR_CYCLES = 400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic [AW-PW-1:0] page_i,
    input  logic [(1<<PW)-1:0] mask_i,
    input  logic [7:0]       bytes_i [1<<PW],
    input  logic [AW-1:0]    rd_addr_i,
    output logic [7:0]       rdata_o,
    output logic             busy_o
);
    localparam int NB    = 1 << PW;
    localparam int DEPTH = 1 << AW;
    localparam int CW    = $clog2(WR_CYCLES + 1);

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] cnt;

    // Page commit: every masked byte goes to its slot in the selected page.
    always_ff @(posedge clk) begin
        if (commit_i) begin
            for (int i = 0; i < NB; i++) begin
                if (mask_i[i]) mem[{page_i, PW'(i)}] <= bytes_i[i];
            end
        end
    end

    // Write-cycle timer, loaded by a commit and counted down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (commit_i)   cnt <= CW'(WR_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy_o  = (cnt != '0);
    assign rdata_o = mem[rd_addr_i];
endmodule

// File: rtl/i2c_slave_engine.sv
// Bit-level transfer engine: shifts bytes in on rising SCL, drives acknowledges and
// read bits after falling SCL, keeps the address pointer and raises the commit request.
// Assumes START/STOP and edge pulses come from the sampler, one cycle wide.
module i2c_slave_engine
    import eeprom_pkg::*;
#(
    parameter int AW = 11,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_p,
    input  logic          stop_p,
    input  logic          wp_i,
    input  logic          busy_i,
    input  logic          mask_any_i,
    input  logic [7:0]    rdata_i,
    output logic          sda_oe_o,
    output logic [AW-1:0] addr_o,
    output logic          buf_clr_o,
    output logic          buf_we_o,
    output logic [PW-1:0] buf_idx_o,
    output logic [7:0]    buf_byte_o,
    output logic          commit_o,
    output logic          rd_load_o
);
    localparam int BW = AW - 8;

    slv_state_t state;
    logic [3:0] bitcnt;
    logic [7:0] shreg, txreg;
    logic       rw, mack;

    // Transfer sequencing; START and STOP override whatever state is current.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            txreg      <= '0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            sda_oe_o   <= 1'b0;
            addr_o     <= '0;
            buf_clr_o  <= 1'b0;
            buf_we_o   <= 1'b0;
            buf_idx_o  <= '0;
            buf_byte_o <= '0;
            commit_o   <= 1'b0;
            rd_load_o  <= 1'b0;
        end else begin
            buf_clr_o <= 1'b0;
            buf_we_o  <= 1'b0;
            commit_o  <= 1'b0;
            rd_load_o <= 1'b0;
            if (start_p) begin
                state     <= ST_DEV;
                bitcnt    <= '0;
                sda_oe_o  <= 1'b0;
                buf_clr_o <= 1'b1;
            end else if (stop_p) begin
                // the STOP's own SCL rise counted one stray bit after a full byte
                if (state == ST_WDATA && bitcnt == 4'd1 && mask_any_i) commit_o <= 1'b1;
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (state == ST_DEV) begin
                                if (shreg[7:4] == DEV_PREFIX && !busy_i) begin
                                    sda_oe_o         <= 1'b1;
                                    rw               <= shreg[0];
                                    addr_o[AW-1:8]   <= shreg[BW:1];
                                    state            <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_WADDR) begin
                                addr_o[7:0] <= shreg;
                                sda_oe_o    <= 1'b1;
                                state       <= ST_WADDR_ACK;
                            end else begin
                                state <= ST_WDATA_ACK;
                                if (!wp_i) begin
                                    sda_oe_o         <= 1'b1;
                                    buf_we_o         <= 1'b1;
                                    buf_idx_o        <= addr_o[PW-1:0];
                                    buf_byte_o       <= shreg;
                                    addr_o[PW-1:0]   <= addr_o[PW-1:0] + 1'b1;
                                end
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                txreg     <= rdata_i;
                                sda_oe_o  <= ~rdata_i[7];
                                bitcnt    <= 4'd1;
                                addr_o    <= addr_o + 1'b1;
                                rd_load_o <= 1'b1;
                                state     <= ST_RDATA;
                            end else begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_WADDR;
                            end
                        end
                    end
                    ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe_o <= 1'b0;
                            bitcnt   <= '0;
                            state    <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_RACK;
                            end else begin
                                sda_oe_o <= ~txreg[6];
                                txreg    <= {txreg[6:0], 1'b0};
                                bitcnt   <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                txreg     <= rdata_i;
                                sda_oe_o  <= ~rdata_i[7];
                                bitcnt    <= 4'd1;
                                addr_o    <= addr_o + 1'b1;
                                rd_load_o <= 1'b1;
                                state     <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/eeprom_i2c_slave.sv
// Top of the serial byte-store slave: wires the sampler, engine, page buffer and store.
// Assumes SDA is an open-drain line; sda_oe_o high pulls it low.
module eeprom_i2c_slave #(
    parameter int MEM_AW    = 11,
    parameter int PAGE_AW   = 5,
    parameter int WR_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);
    localparam int NB = 1 << PAGE_AW;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic              busy, commit, rd_load, buf_clr, buf_we;
    logic [MEM_AW-1:0] addr_q;
    logic [PAGE_AW-1:0] buf_idx;
    logic [7:0]        buf_byte, rdata;
    logic [NB-1:0]     buf_mask;
    logic [7:0]        buf_bytes [NB];

    i2c_line_sampler u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    i2c_slave_engine #(.AW(MEM_AW), .PW(PAGE_AW)) u_engine (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p), .wp_i(wp_i),
        .busy_i(busy), .mask_any_i(|buf_mask), .rdata_i(rdata),
        .sda_oe_o(sda_oe_o), .addr_o(addr_q), .buf_clr_o(buf_clr),
        .buf_we_o(buf_we), .buf_idx_o(buf_idx), .buf_byte_o(buf_byte),
        .commit_o(commit), .rd_load_o(rd_load)
    );

    eeprom_page_buf #(.PW(PAGE_AW)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .we_i(buf_we),
        .idx_i(buf_idx), .byte_i(buf_byte), .mask_o(buf_mask), .bytes_o(buf_bytes)
    );

    eeprom_store #(.AW(MEM_AW), .PW(PAGE_AW), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .commit_i(commit),
        .page_i(addr_q[MEM_AW-1:PAGE_AW]), .mask_i(buf_mask), .bytes_i(buf_bytes),
        .rd_addr_i(addr_q), .rdata_o(rdata), .busy_o(busy)
    );
endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
// Property checker for the serial byte-store slave, attached to the top by bind.
module eeprom_i2c_slave_chk #(
    parameter int AW = 11,
    parameter int PW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          sda_oe,
    input logic          wp,
    input logic          busy,
    input logic          commit,
    input logic          buf_we,
    input logic          rd_load,
    input logic [AW-1:0] addr
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);                                   // R10
    AST_WP_BLOCKS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !$past(wp));                                         // R6
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> addr[AW-1:PW] == $past(addr[AW-1:PW]));              // R4
    AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy);                                              // R7
    AST_COMMIT_STARTS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);                                               // R5
    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |-> addr == $past(addr) + 1'b1);                        // R9
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk #(.AW(MEM_AW), .PW(PAGE_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o), .wp(wp_i),
    .busy(busy), .commit(commit), .buf_we(buf_we), .rd_load(rd_load), .addr(addr_q)
);

// File: tb/eeprom_i2c_slave_bench.sv
// Bench: a bus master model drives transfers; a behavioural scoreboard predicts every byte.
module eeprom_i2c_slave_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_tests = 0, n_fail = 0, oe_viol = 0;
    bit done = 0;
    int mem_ref [2048];
    logic [7:0] wdat [32];
    logic prev_oe = 1'b0;

    always #5 clk = ~clk;

    eeprom_i2c_slave u_eeprom_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .wp_i(wp), .sda_oe_o(sda_oe)
    );

    // R10: every clock, the pull-down may move only while the bus clock is low.
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_oe !== prev_oe)) oe_viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1; tick(4); scl_m = 1; tick(8); sda_m = 0; tick(8); scl_m = 0; tick(4);
    endtask

    task automatic bus_stop;
        sda_m = 0; tick(4); scl_m = 1; tick(8); sda_m = 1; tick(8);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(4); scl_m = 1; tick(8); scl_m = 0; tick(4);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1; tick(4); scl_m = 1; tick(4); b = sda_bus; tick(4); scl_m = 0; tick(4);
    endtask

    task automatic send_byte(input logic [7:0] v, output int ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(x);
        ack = (x == 1'b0) ? 1 : 0;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit more);
        logic x;
        v = '0;
        for (int i = 0; i < 8; i++) begin recv_bit(x); v = {v[6:0], x}; end
        send_bit(more ? 1'b0 : 1'b1);
    endtask

    function automatic logic [7:0] dev_byte(input int a, input bit rd);
        return {4'b1010, 3'((a >> 8) & 7), rd};
    endfunction

    // Page write of n bytes from wdat; model: low five bits wrap inside the page (R4).
    task automatic write_page(input int a, input int n, input logic wp_lvl);
        int ack;
        bus_start;
        send_byte(dev_byte(a, 0), ack); chk("R2 device address ack", ack, 1);
        send_byte(8'(a & 255), ack);    chk("R3 word address ack", ack, 1);
        wp = wp_lvl;
        for (int i = 0; i < n; i++) begin
            send_byte(wdat[i], ack);
            chk(wp_lvl ? "R6 protected byte nack" : "R4 data byte ack", ack, wp_lvl ? 0 : 1);
            if (!wp_lvl) mem_ref[(a & 2016) | ((a + i) & 31)] = wdat[i];
        end
        bus_stop;
        wp = 0;
    endtask

    // Poll the device address until acknowledged; returns the number of NACKs.
    task automatic poll(output int nacks);
        int ack;
        nacks = 0;
        for (int k = 0; k < 20; k++) begin
            bus_start;
            send_byte(8'hA0, ack);
            bus_stop;
            if (ack == 1) break;
            nacks++;
        end
    endtask

    // Random read of n bytes at a, compared against the scoreboard (R8, R9).
    task automatic read_seq(input int a, input int n, input string req);
        int ack;
        logic [7:0] v;
        bus_start;
        send_byte(dev_byte(a, 0), ack); chk("R2 dummy write ack", ack, 1);
        send_byte(8'(a & 255), ack);    chk("R3 word address ack", ack, 1);
        bus_start;
        send_byte(dev_byte(a, 1), ack); chk("R2 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(v, i < n - 1);
            chk(req, int'(v), mem_ref[(a + i) & 2047]);
        end
        chk("R9 SDA released after master nack", int'(sda_oe), 0);
        bus_stop;
    endtask

    initial begin
        int nacks, ack;
        logic [7:0] v;
        tick(5);
        chk("R1 pull-down low in reset", int'(sda_oe), 0);
        rst_n = 1;
        tick(5);
        chk("R1 pull-down low after reset", int'(sda_oe), 0);

        // basic write, busy polling, random read
        for (int i = 0; i < 32; i++) wdat[i] = 8'(8'h30 + i * 7);
        write_page(12'h123, 4, 0);
        poll(nacks);
        chk("R7 busy after commit", int'(nacks >= 1), 1);
        chk("R7 ready within bound", int'(nacks < 10), 1);
        read_seq(12'h123, 4, "R8 random read data");

        // bad prefix
        bus_start;
        send_byte(8'hB0, ack); chk("R2 wrong prefix nack", ack, 0);
        bus_stop;

        // page wrap: guard byte at next page, then 6 bytes from offset 29
        wdat[0] = 8'h5A;
        write_page(12'h220, 1, 0); poll(nacks);
        for (int i = 0; i < 6; i++) wdat[i] = 8'(8'hC0 + i);
        write_page(12'h21D, 6, 0); poll(nacks);
        chk("R4 wrapped write committed", int'(nacks >= 1), 1);
        read_seq(12'h21D, 3, "R4 page tail data");
        read_seq(12'h200, 3, "R4 wrapped page head data");
        read_seq(12'h220, 1, "R4 next page untouched");

        // write protect
        wdat[0] = 8'h11; wdat[1] = 8'h22;
        write_page(12'h300, 2, 0); poll(nacks);
        wdat[0] = 8'hEE; wdat[1] = 8'hDD;
        write_page(12'h300, 2, 1); poll(nacks);
        chk("R6 no write cycle when protected", nacks, 0);
        read_seq(12'h300, 2, "R6 protected data unchanged");

        // STOP part-way through a byte after one full byte
        wdat[0] = 8'h77;
        write_page(12'h310, 1, 0); poll(nacks);
        bus_start;
        send_byte(dev_byte(12'h310, 0), ack); chk("R2 device address ack", ack, 1);
        send_byte(8'h10, ack); chk("R3 word address ack", ack, 1);
        send_byte(8'h99, ack); chk("R5 first byte ack", ack, 1);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop;
        poll(nacks);
        chk("R5 mid-byte stop starts no cycle", nacks, 0);
        read_seq(12'h310, 1, "R5 mid-byte stop discards");

        // rollover across 2047 -> 0, then continue from the pointer
        wdat[0] = 8'hA1; wdat[1] = 8'hA2;
        write_page(2046, 2, 0); poll(nacks);
        for (int i = 0; i < 4; i++) wdat[i] = 8'(8'h40 + i);
        write_page(0, 4, 0); poll(nacks);
        read_seq(2046, 4, "R9 sequential rollover data");
        bus_start;
        send_byte(8'hA1, ack); chk("R9 current read ack", ack, 1);
        recv_byte(v, 0);
        chk("R9 current read continues at pointer", int'(v), mem_ref[2]);
        bus_stop;

        chk("R10 pull-down stable while SCL high", oe_viol, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule